// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block chooses between two unrelated clocks and drives one gated clock from the chosen source. When the select input changes, the block hands over from one source to the other without producing a shortened high or low phase. The old source's leg first parks the output low on one of its own falling edges. The new source's leg then opens on one of its own rising edges, and only after it has seen that the old leg is closed.

Each source has its own leg with an enable register. A leg's enable can only open once the peer leg's enable has been seen low through a synchronizer in the leg's own clock domain. As a result, the two enables are never high together, and the output never carries a fragment of either clock.

A force input exists for the case where the current source has died. A handshake that needs edges from a dead clock would never complete. On a rising edge of force, both legs are closed at once. While force stays high, the leg for the source that is not selected is held closed. The selected leg restarts without waiting for its peer. Force is expected low at power-up and in normal running.

Top module: `glitchfree_clkmux`

## Requirements
- R1: With select high the output follows clock A; with select low it follows clock B. Once a handover is complete, each output high and low phase equals the half-period of the selected clock.
- R2: After a select change, the output parks low on a falling edge of the old clock. This happens no later than three old-clock periods after the change, and produces exactly one long low interval per change.
- R3: The parked low interval lasts at most three periods of the newly selected clock.
- R4: The output resumes with a rising edge of the new clock, so the first high phase after the parked interval is a full half-period of that clock.
- R5: A rising edge on force drives the output low at once, even when the old clock has stopped with the output high.
- R6: After a force rising edge, the output restarts on the clock named by select, within six of that clock's periods.
- R7: While force is high, the clock that select does not name has no effect on the output, even when it is stopped or toggling erratically.
- R8: While force is in use, a switch is made by lowering force, changing select and raising force again; the output then follows the newly selected clock, and it keeps doing so without interruption after force is lowered.
- R9: While reset is high, both leg enables are clear and the output is low. After reset is released, the output starts on the clock named by select at that moment.
- R10: Outside a force rising edge or a reset, no output high or low phase is shorter than the smaller half-period of the two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | Source clock A, chosen when select is high |
| clk_b_i | input | 1 | Source clock B, chosen when select is low |
| rst_i | input | 1 | Active-high reset; asserts asynchronously and clears both legs |
| sel_i | input | 1 | Source select: 1 picks clock A, 0 picks clock B |
| force_i | input | 1 | Force switchover; a rising edge closes both legs and drops the handshake |
| clk_o | output | 1 | Gated output clock |

## Verification
The two clocks run at unrelated rates with distinct half-periods, so the width of every output phase shows which source is driving. Each table-driven switch is applied at a different phase offset against both clocks. This exposes park and resume delays across the range of alignments, and shows whether a runt is cut at either end. A burst of select toggles faster than either clock checks that aborted handovers still settle cleanly. Stopping clock A with the output high, and then making it erratic, separates the force path from the normal handshake. These cases show whether force closes the output immediately and whether the deselected source can still leak through.

// File: rtl/clkmux_pkg.sv
`timescale 1ns/1ps
package clkmux_pkg;

  // number of selectable sources
  localparam int unsigned CLKMUX_NSRC = 2;
  // index of each leg in the per-leg vectors
  localparam int unsigned CLKMUX_IDX_A = 0;
  localparam int unsigned CLKMUX_IDX_B = 1;

  // select value that routes a given leg to the output
  function automatic logic clkmux_leg_wanted(input logic sel, input int unsigned idx);
    return (idx == CLKMUX_IDX_A) ? sel : ~sel;
  endfunction

  // index of the other leg
  function automatic int unsigned clkmux_peer(input int unsigned idx);
    return (CLKMUX_NSRC - 1) - idx;
  endfunction

endpackage

// File: rtl/clkmux_sync.sv
`timescale 1ns/1ps
// Flop chain for bringing a level into one clock domain, cleared by an
// asynchronous reset.
module clkmux_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) chain <= '0;
        else        chain <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/clkmux_leg.sv
`timescale 1ns/1ps
// One source leg: request synchronizer, force-seen synchronizer and the
// falling-edge enable that gates this leg's clock onto the output.
module clkmux_leg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic force_i,
  input  logic want_i,
  input  logic peer_en_i,
  output logic en_o,
  output logic gated_o
);

  logic force_clr;
  logic force_seen;
  logic leg_rst;
  logic req;
  logic req_sync;
  logic en_q;

  // force is seen in this domain only while it stays high
  assign force_clr = rst_i | ~force_i;

  clkmux_sync #(.STAGES(SYNC_STAGES)) u_force_sync (
    .clk_i  (clk_i),
    .arst_i (force_clr),
    .d_i    (1'b1),
    .q_o    (force_seen)
  );

  // closed during reset, while force is high for a deselected leg, and
  // from a force rising edge until this domain has registered it
  assign leg_rst = rst_i | (force_i & ~want_i) | (force_i & ~force_seen);

  // normal request waits for the peer to be closed; force skips that wait
  assign req = want_i & (~peer_en_i | force_i);

  clkmux_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (clk_i),
    .arst_i (leg_rst),
    .d_i    (req),
    .q_o    (req_sync)
  );

  // enable moves only while this clock is low
  always_ff @(negedge clk_i or posedge leg_rst) begin
    if (leg_rst) en_q <= 1'b0;
    else         en_q <= req_sync;
  end

  assign en_o    = en_q;
  assign gated_o = clk_i & en_q;

endmodule

// File: rtl/glitchfree_clkmux.sv
`timescale 1ns/1ps
module glitchfree_clkmux
  import clkmux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_i,
  input  logic sel_i,
  input  logic force_i,
  output logic clk_o
);

  logic [CLKMUX_NSRC-1:0] src_clk;
  logic [CLKMUX_NSRC-1:0] leg_en;
  logic [CLKMUX_NSRC-1:0] leg_out;

  assign src_clk[CLKMUX_IDX_A] = clk_a_i;
  assign src_clk[CLKMUX_IDX_B] = clk_b_i;

  generate
    for (genvar g = 0; g < CLKMUX_NSRC; g++) begin : g_leg
      clkmux_leg #(.SYNC_STAGES(SYNC_STAGES)) u_leg (
        .clk_i     (src_clk[g]),
        .rst_i     (rst_i),
        .force_i   (force_i),
        .want_i    (clkmux_leg_wanted(sel_i, g)),
        .peer_en_i (leg_en[clkmux_peer(g)]),
        .en_o      (leg_en[g]),
        .gated_o   (leg_out[g])
      );
    end
  endgenerate

  assign clk_o = |leg_out;

endmodule

// File: rtl/glitchfree_clkmux_chk.sv
`timescale 1ns/1ps
module glitchfree_clkmux_chk (
  input logic clk_a_i,
  input logic clk_b_i,
  input logic rst_i,
  input logic sel_i,
  input logic force_i,
  input logic clk_o,
  input logic en_a,
  input logic en_b
);

  // R10: the two leg enables are never open together
  a_r10_excl_a: assert property (@(posedge clk_a_i) disable iff (rst_i)
    !(en_a && en_b));
  a_r10_excl_b: assert property (@(posedge clk_b_i) disable iff (rst_i)
    !(en_a && en_b));

  // R2: a leg whose select has been away for three of its edges is closed
  a_r2_old_a: assert property (@(posedge clk_a_i) disable iff (rst_i)
    (!sel_i && $past(!sel_i) && $past(!sel_i, 2)) |-> !en_a);
  a_r2_old_b: assert property (@(posedge clk_b_i) disable iff (rst_i)
    (sel_i && $past(sel_i) && $past(sel_i, 2)) |-> !en_b);

  // R3: a leg opens only when its select was seen two edges earlier
  a_r3_new_a: assert property (@(posedge clk_a_i) disable iff (rst_i || force_i)
    $rose(en_a) |-> $past(sel_i, 2));
  a_r3_new_b: assert property (@(posedge clk_b_i) disable iff (rst_i || force_i)
    $rose(en_b) |-> $past(!sel_i, 2));

  // R7: with force held, the deselected leg stays closed
  a_r7_desel_b: assert property (@(posedge clk_b_i) disable iff (rst_i)
    (force_i && sel_i && $past(force_i && sel_i)) |-> !en_b);
  a_r7_desel_a: assert property (@(posedge clk_a_i) disable iff (rst_i)
    (force_i && !sel_i && $past(force_i && !sel_i)) |-> !en_a);

  // R9: during reset both legs are closed and the output is low
  always @(negedge clk_a_i) begin
    if (rst_i) begin
      a_r9_rst_clear: assert (!en_a && !en_b && !clk_o);
    end
  end

endmodule

bind glitchfree_clkmux glitchfree_clkmux_chk u_chk (
  .clk_a_i (clk_a_i),
  .clk_b_i (clk_b_i),
  .rst_i   (rst_i),
  .sel_i   (sel_i),
  .force_i (force_i),
  .clk_o   (clk_o),
  .en_a    (leg_en[0]),
  .en_b    (leg_en[1])
);

// File: tb/glitchfree_clkmux_tb_top.sv
`timescale 1ns/1ps
module glitchfree_clkmux_tb_top;

  localparam real HA     = 6.0;   // clock A half-period
  localparam real HB     = 8.5;   // clock B half-period
  localparam real MINH   = 6.0;   // smaller half-period
  localparam real GAP_TH = 12.75; // low phase longer than this is a park
  localparam int  VEC_N  = 6;
  // {new select, phase offset in ns}
  localparam logic [8:0] VEC [VEC_N] = '{
    {1'b0, 8'd3}, {1'b1, 8'd7}, {1'b0, 8'd11},
    {1'b1, 8'd2}, {1'b0, 8'd5}, {1'b1, 8'd9}
  };

  logic clk   = 1'b0;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst   = 1'b1;
  logic sel   = 1'b1;
  logic frc   = 1'b0;
  logic clk_o;
  int   a_mode = 0;

  glitchfree_clkmux dut_i (
    .clk_a_i (clk_a),
    .clk_b_i (clk_b),
    .rst_i   (rst),
    .sel_i   (sel),
    .force_i (frc),
    .clk_o   (clk_o)
  );

  always #2.5 clk = ~clk;
  always #(HB) clk_b = ~clk_b;
  always begin
    case (a_mode)
      0: begin #(HA); clk_a = ~clk_a; end
      1: #(1.0);
      default: begin
        #(1.7); clk_a = ~clk_a;
        #(0.9); clk_a = ~clk_a;
        #(4.1); clk_a = ~clk_a;
      end
    endcase
  end

  // output phase monitor
  realtime t_rise = 0, t_fall = 0, hi_w = 0, lo_w = 0;
  realtime gap_s = 0, gap_e = -1, post_gap_hi = 0, exempt_until = 50;
  int runts = 0, gaps = 0;

  always @(posedge clk_o) begin
    lo_w = $realtime - t_fall;
    if ($realtime >= exempt_until && lo_w < MINH - 0.1) runts++;
    if (lo_w > GAP_TH) begin
      gap_s = t_fall;
      gap_e = $realtime;
      gaps++;
    end
    t_rise = $realtime;
  end

  always @(negedge clk_o) begin
    hi_w = $realtime - t_rise;
    if ($realtime >= exempt_until && hi_w < MINH - 0.1) runts++;
    if (t_rise == gap_e) post_gap_hi = hi_w;
    t_fall = $realtime;
  end

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  int wd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return ((a - b) < 0.3) && ((b - a) < 0.3);
  endfunction

  always @(posedge clk) begin
    if (!done) begin
      wd++;
      if (wd > 150000) begin
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  logic    nsel;
  real     oh, nh;
  realtime t0;
  int      g0, r0;

  initial begin
    // R9: output held low during reset
    #40;
    chk(clk_o === 1'b0, "R9", "output in reset", clk_o, 0);
    #23.3;
    chk(clk_o === 1'b0, "R9", "output in reset later", clk_o, 0);
    @(negedge clk); rst = 1'b0;
    #400;
    chk(near(hi_w, HA), "R9", "high phase after release (A)", hi_w, HA);
    chk(near(lo_w, HA), "R1", "low phase on A", lo_w, HA);

    // table of switches at varied phase offsets
    for (int i = 0; i < VEC_N; i++) begin
      nsel = VEC[i][8];
      oh = sel ? HA : HB;
      nh = nsel ? HA : HB;
      g0 = gaps;
      r0 = runts;
      @(negedge clk);
      #(real'(VEC[i][7:0]) + 0.3);
      t0 = $realtime;
      sel = nsel;
      #500;
      chk(gaps == g0 + 1, "R2", "park events", gaps - g0, 1);
      chk(gap_s >= t0 && (gap_s - t0) <= 6.0 * oh + 0.1, "R2", "park delay",
          gap_s - t0, 6.0 * oh);
      chk((gap_e - gap_s) <= 6.0 * nh + 0.1, "R3", "parked interval",
          gap_e - gap_s, 6.0 * nh);
      chk(near(post_gap_hi, nh), "R4", "first high phase", post_gap_hi, nh);
      chk(near(hi_w, nh) && near(lo_w, nh), "R1", "source phase", hi_w, nh);
      chk(runts == r0, "R10", "runt count", runts - r0, 0);
    end

    // rapid select toggles (sel is 1 here)
    r0 = runts;
    @(negedge clk); #0.3;
    sel = 1'b0; #9; sel = 1'b1; #5; sel = 1'b0;
    #500;
    chk(near(hi_w, HB) && near(lo_w, HB), "R1", "settled after toggles", hi_w, HB);
    chk(runts == r0, "R10", "runts after toggles", runts - r0, 0);

    // back to A, then let A die while high
    sel = 1'b1;
    #500;
    @(negedge clk_a); #1; a_mode = 1;
    #60;
    chk(clk_o === 1'b1, "R5", "output stuck with dead A", clk_o, 1);
    sel = 1'b0;
    #100.3;
    exempt_until = $realtime + 40;
    frc = 1'b1;
    #0.5;
    chk(clk_o === 1'b0, "R5", "output after force edge", clk_o, 0);
    #400;
    chk(near(hi_w, HB) && near(lo_w, HB), "R6", "restart on B", hi_w, HB);

    // erratic deselected clock while force held
    g0 = gaps;
    r0 = runts;
    a_mode = 2;
    #300;
    chk(near(hi_w, HB) && near(lo_w, HB), "R7", "phase with erratic A", hi_w, HB);
    chk(gaps == g0, "R7", "no interruption", gaps - g0, 0);
    chk(runts == r0, "R7", "no runts from A", runts - r0, 0);
    a_mode = 0;
    #100;

    // switch under force
    frc = 1'b0;
    #40;
    chk(near(hi_w, HB) && gaps == g0, "R8", "B kept after force low", hi_w, HB);
    sel = 1'b1;
    #10;
    exempt_until = $realtime + 40;
    frc = 1'b1;
    #500;
    chk(near(hi_w, HA) && near(lo_w, HA), "R8", "A after force switch", hi_w, HA);
    g0 = gaps;
    frc = 1'b0;
    #200;
    chk(near(hi_w, HA) && gaps == g0, "R8", "A kept after force low", hi_w, HA);

    // reset mid-run, select changed under reset
    sel = 1'b0;
    #500;
    exempt_until = $realtime + 1000;
    rst = 1'b1;
    #30.3;
    chk(clk_o === 1'b0, "R9", "output in mid-run reset", clk_o, 0);
    sel = 1'b1;
    #30;
    chk(clk_o === 1'b0, "R9", "output in reset after select", clk_o, 0);
    @(negedge clk); rst = 1'b0;
    #400;
    chk(near(hi_w, HA) && near(lo_w, HA), "R9", "start on selected A", hi_w, HA);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule